// File: doc/BRIEF.md
# Bit-Serial Synapse Stage

This block is one link in a chain of synapse stages that forms a dendrite of a digital spiking neuron. Two serial lines cross the stage. The outward line carries membrane-potential packets from the soma toward the leaves of the dendrite. The stage only re-times that line, through one register. The return line carries a running sum back toward the soma. When the stage has seen a presynaptic spike, it adds its signed synaptic weight into the next packet on the return line. It does this one bit per clock, while the packet is still passing through. When no spike is pending, the packet passes through untouched, with the same one-clock delay.

The weight lives in a circulating shift register. It rotates by one position for each data bit that it adds, so after a full packet it is back in its original alignment and can be used again. A new weight can be written through the load port, but only while no packet is passing through the stage. Chaining many stages lets the soma receive its potential plus the sum of all weights whose spikes fired during the last round trip.

Top module: `serial_synapse_stage`

## Requirements
- R1: A packet is one start bit of value 1 followed by DATA_W data bits, least significant bit first, in two's complement. An idle line is held at 0. The return line's start bit appears on `dn_o` exactly one clock after it is seen on `dn_i`, whether or not the stage is adding.
- R2: `up_o` equals `up_i` delayed by exactly one clock, at all times after reset.
- R3: When no spike was pending at a packet's start bit, every bit of that packet appears unchanged on `dn_o` one clock after it enters on `dn_i`.
- R4: When a spike was pending at a packet's start bit, the carry is cleared at that start bit. The packet's data field on `dn_o` is then (input data + weight) modulo 2^DATA_W, still least significant bit first, with one clock of latency.
- R5: A spike that is high in the same clock as a start bit does not affect that packet. It is held and applies to the next packet.
- R6: A spike that arrives while a packet is passing through is held and applies to the following packet. Several spikes before one packet cause a single addition.
- R7: After an adding packet, the weight is intact, so consecutive adding packets all add the same value.
- R8: A pulse on `wload_en_i` replaces the weight with `wload_val_i` when the stage is not inside a packet's data bits. Such a pulse during the data bits has no effect on this packet or later ones.
- R9: Reset drives `up_o` and `dn_o` to 0, clears any pending spike, and sets the weight to RESET_WEIGHT.
- R10: Packets that follow each other with no idle clock between them are each handled correctly. This includes the pass-through or add decision and the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spike_i | input | 1 | Presynaptic spike, one clock pulse |
| up_i | input | 1 | Outward serial line in |
| up_o | output | 1 | Outward serial line out, re-timed |
| dn_i | input | 1 | Return serial line in |
| dn_o | output | 1 | Return serial line out, with the weight added when armed |
| wload_en_i | input | 1 | Weight write strobe |
| wload_val_i | input | DATA_W | Weight value to write, two's complement |

## Verification
The bench builds the stage with its defaults: DATA_W of 16 and a RESET_WEIGHT of zero. The 16-bit width lets the vectors reach the real wrap points: 0xFFFF plus 1, the crossing from 0x7FFF to 0x8000, and 0x8000 plus 0x8000. The zero reset weight makes an armed packet right after reset come out unchanged, which shows that reset restores the weight. A 34-bit stream holds two packets back to back, so the start-bit decision is exercised with no idle gap between packets.

// File: rtl/syn_stage_pkg.sv
package syn_stage_pkg;

    // Where the stage is with respect to the return-line packet
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // between packets, watching for a start bit
        PH_PASS = 2'd1,   // data bits flowing through untouched
        PH_ADD  = 2'd2    // data bits receiving the weight
    } phase_e;

endpackage

// File: rtl/syn_stage_ctrl.sv
module syn_stage_ctrl
    import syn_stage_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   spike_i,
    input  logic   dn_i,
    output phase_e phase_o,
    output logic   start_o
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e           phase;
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = (st_q.phase == PH_IDLE) && dn_i;
        if (st_q.phase == PH_IDLE) begin
            if (dn_i) begin
                // Start bit: the pending spike decides this packet; a
                // spike in this same clock is kept for the next one.
                st_d.phase = st_q.pend ? PH_ADD : PH_PASS;
                st_d.cnt   = '0;
                st_d.pend  = spike_i;
            end else begin
                st_d.pend = st_q.pend | spike_i;
            end
        end else begin
            st_d.pend = st_q.pend | spike_i;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_BIT) begin
                st_d.phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, pend: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

endmodule

// File: rtl/syn_weight_ring.sv
module syn_weight_ring #(
    parameter int              DATA_W       = 16,
    parameter logic [DATA_W-1:0] RESET_WEIGHT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rot_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    output logic [DATA_W-1:0] ring_o
);

    logic [DATA_W-1:0] ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (load_i) begin
            ring_d = load_val_i;
        end else if (rot_i) begin
            // Rotate right: bit 0 feeds the adder, then re-enters at the top
            ring_d = {ring_q[0], ring_q[DATA_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= RESET_WEIGHT;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign ring_o = ring_q;

endmodule

// File: rtl/syn_bit_adder.sv
module syn_bit_adder (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic a_i,
    input  logic b_i,
    output logic sum_o
);

    logic carry_d, carry_q;

    always_comb begin
        sum_o   = a_i ^ b_i ^ carry_q;
        carry_d = carry_q;
        if (clr_i) begin
            carry_d = 1'b0;
        end else if (en_i) begin
            carry_d = (a_i & b_i) | (a_i & carry_q) | (b_i & carry_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else begin
            carry_q <= carry_d;
        end
    end

endmodule

// File: rtl/serial_synapse_stage.sv
module serial_synapse_stage
    import syn_stage_pkg::*;
#(
    parameter int                DATA_W       = 16,
    parameter logic [DATA_W-1:0] RESET_WEIGHT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spike_i,
    input  logic              up_i,
    output logic              up_o,
    input  logic              dn_i,
    output logic              dn_o,
    input  logic              wload_en_i,
    input  logic [DATA_W-1:0] wload_val_i
);

    typedef struct packed {
        logic up;
        logic dn;
    } lines_t;

    phase_e            phase;
    logic              start;
    logic              adding;
    logic              load_ok;
    logic              sum_bit;
    logic [DATA_W-1:0] ring;
    lines_t            ln_d, ln_q;

    syn_stage_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .spike_i (spike_i),
        .dn_i    (dn_i),
        .phase_o (phase),
        .start_o (start)
    );

    assign adding  = (phase == PH_ADD);
    assign load_ok = wload_en_i && (phase == PH_IDLE);

    syn_weight_ring #(.DATA_W(DATA_W), .RESET_WEIGHT(RESET_WEIGHT)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .rot_i      (adding),
        .load_i     (load_ok),
        .load_val_i (wload_val_i),
        .ring_o     (ring)
    );

    syn_bit_adder u_add (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start),
        .en_i  (adding),
        .a_i   (dn_i),
        .b_i   (ring[0]),
        .sum_o (sum_bit)
    );

    always_comb begin
        ln_d.up = up_i;
        ln_d.dn = adding ? sum_bit : dn_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign up_o = ln_q.up;
    assign dn_o = ln_q.dn;

endmodule

// File: rtl/syn_stage_chk.sv
module syn_stage_chk
    import syn_stage_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_i,
    input logic              up_o,
    input logic              dn_i,
    input logic              dn_o,
    input logic              wload_en_i,
    input phase_e            phase,
    input logic [DATA_W-1:0] ring
);

    // R2: outward line is a pure one-clock delay
    assert_up_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (up_o == $past(up_i)));

    // R3: outside an adding packet the return line is a one-clock delay
    assert_dn_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_ADD) |=> (dn_o == $past(dn_i)));

    // R1: a start bit seen between packets shows up one clock later
    assert_start_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && dn_i) |=> dn_o);

    // R10: a start bit always opens a packet phase
    assert_start_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && dn_i) |=> (phase != PH_IDLE));

    // R8: weight is frozen unless adding or loading between packets
    assert_weight_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_ADD && !(phase == PH_IDLE && wload_en_i)) |=> $stable(ring));

endmodule

bind serial_synapse_stage syn_stage_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_i       (up_i),
    .up_o       (up_o),
    .dn_i       (dn_i),
    .dn_o       (dn_o),
    .wload_en_i (wload_en_i),
    .phase      (phase),
    .ring       (ring)
);

// File: tb/serial_synapse_stage_bench.sv
`timescale 1ns/1ps
module serial_synapse_stage_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         spike_i = 1'b0;
    logic         up_i = 1'b0;
    logic         dn_i = 1'b0;
    logic         wload_en_i = 1'b0;
    logic [W-1:0] wload_val_i = '0;
    logic         up_o, dn_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    serial_synapse_stage u_serial_synapse_stage (
        .clk(clk), .rst_n(rst_n), .spike_i(spike_i), .up_i(up_i), .up_o(up_o),
        .dn_i(dn_i), .dn_o(dn_o), .wload_en_i(wload_en_i), .wload_val_i(wload_val_i)
    );

    // weight[48:33] data[32:17] arm[16] expected[15:0]
    localparam logic [48:0] VEC [9] = '{
        {16'h0003, 16'h0005, 1'b1, 16'h0008},
        {16'h0003, 16'h1234, 1'b0, 16'h1234},
        {16'hFFFF, 16'h0001, 1'b1, 16'h0000},
        {16'h7FFF, 16'h0001, 1'b1, 16'h8000},
        {16'h8000, 16'h8000, 1'b1, 16'h0000},
        {16'h00FF, 16'hFF01, 1'b1, 16'h0000},
        {16'h1111, 16'h2222, 1'b1, 16'h3333},
        {16'hABCD, 16'h0000, 1'b0, 16'h0000},
        {16'hFFFE, 16'h0005, 1'b1, 16'h0003}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] pkt(input logic [15:0] d);
        return {d, 1'b1};
    endfunction

    // Drive n bits (index 0 first); cd/cu[k] is the output one clock after bit k
    task automatic stream(input logic [63:0] dv, input logic [63:0] uv,
                          input logic [63:0] sv, input logic [63:0] lv, input int n,
                          output logic [63:0] cd, output logic [63:0] cu);
        cd = '0;
        cu = '0;
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            if (k > 0) begin
                cd[k-1] = dn_o;
                cu[k-1] = up_o;
            end
            if (k < n) begin
                dn_i = dv[k]; up_i = uv[k]; spike_i = sv[k]; wload_en_i = lv[k];
            end else begin
                dn_i = 1'b0; up_i = 1'b0; spike_i = 1'b0; wload_en_i = 1'b0;
            end
        end
    endtask

    task automatic pulse_spike();
        @(negedge clk); spike_i = 1'b1;
        @(negedge clk); spike_i = 1'b0;
    endtask

    task automatic load_w(input logic [15:0] w);
        @(negedge clk); wload_en_i = 1'b1; wload_val_i = w;
        @(negedge clk); wload_en_i = 1'b0;
    endtask

    task automatic one_pkt(input logic [15:0] d, output logic [15:0] res, output logic st);
        logic [63:0] cd, cu;
        stream({47'd0, pkt(d)}, 64'd0, 64'd0, 64'd0, 17, cd, cu);
        res = cd[16:1];
        st  = cd[0];
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] cd, cu;
        logic [15:0] r;
        logic        st;

        // R9: outputs low while in reset
        repeat (3) @(negedge clk);
        check("R9 dn_o in reset", {31'd0, dn_o}, 32'd0);
        check("R9 up_o in reset", {31'd0, up_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R1 R2 R3 R4
        for (int i = 0; i < 9; i++) begin
            logic [15:0] w, d, e;
            logic        arm;
            logic [16:0] upk;
            w = VEC[i][48:33]; d = VEC[i][32:17]; arm = VEC[i][16]; e = VEC[i][15:0];
            upk = pkt(d ^ 16'hA5A5);
            load_w(w);
            if (arm) pulse_spike();
            stream({47'd0, pkt(d)}, {47'd0, upk}, 64'd0, 64'd0, 17, cd, cu);
            check("R1 start bit", {31'd0, cd[0]}, 32'd1);
            check(arm ? "R4 armed sum" : "R3 pass through", {16'd0, cd[16:1]}, {16'd0, e});
            check("R2 upstream copy", {15'd0, cu[16:0]}, {15'd0, upk});
        end

        // R5: spike coincident with the start bit applies to the next packet
        load_w(16'h0010);
        stream({30'd0, pkt(16'h0100), pkt(16'h0100)}, 64'd0, 64'd1, 64'd0, 34, cd, cu);
        check("R5 coincident spike skipped", {16'd0, cd[16:1]}, 32'h0100);
        check("R5 coincident spike next pkt", {16'd0, cd[33:18]}, 32'h0110);
        check("R10 second start bit", {31'd0, cd[17]}, 32'd1);

        // R6 R7: spike mid-packet held for the following packet
        load_w(16'h0020);
        pulse_spike();
        stream({47'd0, pkt(16'h0001)}, 64'd0, 64'd32, 64'd0, 17, cd, cu);
        check("R6 armed packet", {16'd0, cd[16:1]}, 32'h0021);
        one_pkt(16'h0002, r, st);
        check("R7 reused weight", {16'd0, r}, 32'h0022);
        one_pkt(16'h0003, r, st);
        check("R6 no more pending", {16'd0, r}, 32'h0003);

        // R6: several spikes, one addition
        pulse_spike(); pulse_spike(); pulse_spike();
        one_pkt(16'h0100, r, st);
        check("R6 multi spike once", {16'd0, r}, 32'h0120);
        one_pkt(16'h0100, r, st);
        check("R6 multi spike not repeated", {16'd0, r}, 32'h0100);

        // R8: load strobe during data bits ignored
        load_w(16'h0010);
        pulse_spike();
        wload_val_i = 16'h0700;
        stream({47'd0, pkt(16'h0001)}, 64'd0, 64'd0, 64'h7F8, 17, cd, cu);
        check("R8 load mid packet ignored", {16'd0, cd[16:1]}, 32'h0011);
        pulse_spike();
        one_pkt(16'h0001, r, st);
        check("R8 weight kept after ignored load", {16'd0, r}, 32'h0011);
        load_w(16'h0700);
        pulse_spike();
        one_pkt(16'h0001, r, st);
        check("R8 idle load taken", {16'd0, r}, 32'h0701);

        // R10: back-to-back packets, both armed
        load_w(16'h0005);
        pulse_spike();
        stream({30'd0, pkt(16'hFFFF), pkt(16'h0001)}, 64'd0, 64'd8, 64'd0, 34, cd, cu);
        check("R10 first of pair", {16'd0, cd[16:1]}, 32'h0006);
        check("R10 second of pair", {16'd0, cd[33:18]}, 32'h0004);

        // R9: reset clears pending spike and restores the weight
        pulse_spike();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R9 dn_o after reset", {31'd0, dn_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        load_w(16'h0001);
        one_pkt(16'h4321, r, st);
        check("R9 pending cleared", {16'd0, r}, 32'h4321);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        pulse_spike();
        one_pkt(16'h4321, r, st);
        check("R9 weight restored", {16'd0, r}, 32'h4321);
        check("R1 start after reset", {31'd0, st}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule